// File: doc/BRIEF.md
# Trigger Clock-and-Control Master

This block sits between an upstream trigger source and up to four crate-level slave controllers. Each cycle of the 96 ns clock it captures the upstream accept, test-pulse, bunch-number and trigger-type inputs into registers. From the captured accept and test-pulse bits it produces a trigger-in pulse and a test-pulse strobe, registers them a second time and sends them to the front-end interface. The readout clock is forwarded with them. Clock-phase tuning is out of scope, so the readout clock is the block clock.

Every slave returns three lines: busy, reset request and fatal error. A per-slave mask removes a slave's returns before they are combined. The combined busy and fatal lines go back upstream. A small control state machine turns an unmasked reset request into a fixed-width active-low front-end reset. An unmasked fatal error locks the machine into a fatal state, which only a global reset written to the command register releases.

A single-cycle register bus holds the command and mask registers, four trigger-emulation registers and two read-only status registers. In local test mode the emulation registers take the place of the upstream inputs. Writes to the accept and test-pulse registers then act as one-shot pulses.

Top module: `ccm_master`

## Requirements
- R1: After rst_n is released, trig_o, testp_o, busy_o and fatal_o are 0, fe_rst_n_o is 1, the state field reads RUN (0), and the command and mask registers read 0 (upstream mode, nothing masked).
- R2: In upstream mode an input value on up_accept_i / up_testp_i present at clock edge k appears on trig_o / testp_o for the cycle after edge k+1. The bunch and type inputs present at edge k read back at addresses 4 and 5 after edge k.
- R3: busy_o is 1 when any slave busy line whose mask bit is 0 is high, or when the state is not RUN. Otherwise it is 0. Mask register bit n (address 1, bits 3:0), when set, removes all three returns of slave n.
- R4: fatal_o is 1 when any unmasked slave fatal line is high or the state is FATAL. Otherwise it is 0.
- R5: An unmasked reset request seen in RUN moves the state to RESETTING (1). fe_rst_n_o is then 0 for exactly 4 cycles and busy_o stays 1. The state returns to RUN at the first edge after those 4 cycles on which no unmasked reset request is high. A masked reset request has no effect.
- R6: An unmasked fatal error moves the state to FATAL (2) from any state. The FATAL state persists even after the fatal line drops or gets masked, until a command-register global reset.
- R7: Command register (address 0): bit 0 selects local mode (1) or upstream mode (0) and reads back. Writing bit 1 as 1 issues a global reset that returns the state to RUN on that edge; bit 1 reads as 0.
- R8: The mask register (address 1, bits 3:0) is writable and readable in both modes.
- R9: In local mode, writing 1 to bit 0 of address 2 (accept) or address 3 (test pulse) gives one single-cycle pulse on trig_o / testp_o, with the same two-edge latency as R2. Writes to addresses 4 and 5 set the bunch and type values read back. The upstream inputs are ignored. In upstream mode, writes to addresses 2 to 5 are ignored and the live captured upstream values read back.
- R10: Address 6 reads {fatal[3:0], reset-request[3:0], busy[3:0]} of the slaves in bits 11:8, 7:4 and 3:0. Address 7 reads the state in bits 1:0, trig_o in bit 2, testp_o in bit 3 and fe_rst_n_o in bit 4.
- R11: A captured accept yields no trig_o pulse while the state is not RUN.
- R12: ro_clk_o follows the block clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 96 ns block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_accept_i | input | 1 | Upstream trigger accept |
| up_testp_i | input | 1 | Upstream test-pulse request |
| up_bunch_i | input | 8 | Upstream bunch number |
| up_type_i | input | 4 | Upstream trigger type |
| sl_busy_i | input | 4 | Busy return, one per slave |
| sl_err_i | input | 4 | Reset-request return, one per slave |
| sl_fatal_i | input | 4 | Fatal-error return, one per slave |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data (combinational) |
| trig_o | output | 1 | Trigger-in pulse to front end |
| testp_o | output | 1 | Test-pulse strobe to front end |
| ro_clk_o | output | 1 | Readout clock to front end |
| busy_o | output | 1 | Busy return upstream |
| fatal_o | output | 1 | Fatal-error return upstream |
| fe_rst_n_o | output | 1 | Active-low front-end reset |

## Verification
The assertions assume that the reset-request width is at least two cycles. They also assume that slave returns and bus inputs change only between clock edges and are stable around the sampling edge. The bench drives every input on the falling edge and keeps the default reset width, so both conditions hold. During the random phase the reset-request and fatal lines stay low, which keeps the machine in RUN. The state-machine paths are then exercised by directed sequences whose slave returns are set and cleared on known cycles.

// File: rtl/ccm_pkg.sv
// Shared types and register addresses for the clock-and-control master.
// Assumes a 3-bit register address space with eight word locations.
package ccm_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_RESETTING = 2'd1,
        ST_FATAL     = 2'd2
    } ccm_state_e;

    localparam int          ADDR_W     = 3;
    localparam logic [2:0]  A_CMD      = 3'd0;
    localparam logic [2:0]  A_MASK     = 3'd1;
    localparam logic [2:0]  A_EMU_ACC  = 3'd2;
    localparam logic [2:0]  A_EMU_TP   = 3'd3;
    localparam logic [2:0]  A_EMU_BX   = 3'd4;
    localparam logic [2:0]  A_EMU_TYP  = 3'd5;
    localparam logic [2:0]  A_STAT_SL  = 3'd6;
    localparam logic [2:0]  A_STAT_FE  = 3'd7;

endpackage

// File: rtl/ccm_return_combiner.sv
// Masks the busy, reset-request and fatal returns per slave and ORs each
// kind into one flag. Purely combinational; a set mask bit hides a slave.
module ccm_return_combiner #(
    parameter int N_SLAVE = 4
) (
    input  logic [N_SLAVE-1:0] busy_i,
    input  logic [N_SLAVE-1:0] err_i,
    input  logic [N_SLAVE-1:0] fatal_i,
    input  logic [N_SLAVE-1:0] mask_i,
    output logic               busy_any_o,
    output logic               err_any_o,
    output logic               fatal_any_o
);

    logic [N_SLAVE-1:0] busy_m;
    logic [N_SLAVE-1:0] err_m;
    logic [N_SLAVE-1:0] fatal_m;

    // One gating cell per slave
    for (genvar s = 0; s < N_SLAVE; s++) begin : g_slave
        assign busy_m[s]  = busy_i[s]  & ~mask_i[s];
        assign err_m[s]   = err_i[s]   & ~mask_i[s];
        assign fatal_m[s] = fatal_i[s] & ~mask_i[s];
    end

    // Reduce each return kind to one flag
    always_comb begin
        busy_any_o  = |busy_m;
        err_any_o   = |err_m;
        fatal_any_o = |fatal_m;
    end

endmodule

// File: rtl/ccm_ctrl_fsm.sv
// Control state machine: RUN, RESETTING (timed front-end reset) and FATAL
// (sticky). Assumes glob_rst_i is a single-cycle pulse from the register bus.
module ccm_ctrl_fsm
    import ccm_pkg::*;
#(
    parameter int RST_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       glob_rst_i,
    input  logic       err_any_i,
    input  logic       fatal_any_i,
    output ccm_state_e state_o,
    output logic       fe_rst_n_o
);

    localparam int CNT_W = $clog2(RST_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(RST_CYC);

    ccm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state decision; global reset outranks fatal, fatal outranks all else
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (glob_rst_i) begin
            state_d = ST_RUN;
            cnt_d   = '0;
        end else if (fatal_any_i) begin
            state_d = ST_FATAL;
        end else begin
            case (state_q)
                ST_RUN: begin
                    if (err_any_i) begin
                        state_d = ST_RESETTING;
                        cnt_d   = '0;
                    end
                end
                ST_RESETTING: begin
                    if (cnt_q < CNT_END) begin
                        cnt_d = cnt_q + 1'b1;
                    end else if (!err_any_i) begin
                        state_d = ST_RUN;
                    end
                end
                default: ;
            endcase
        end
    end

    // State and reset-width counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Front-end reset is low for the first RST_CYC cycles of RESETTING
    always_comb begin
        state_o    = state_q;
        fe_rst_n_o = !((state_q == ST_RESETTING) && (cnt_q < CNT_END));
    end

endmodule

// File: rtl/ccm_trigger_path.sv
// Captures upstream trigger inputs (or, in local mode, bus-written values)
// on the block clock, then re-registers the accept and test-pulse bits as
// front-end outputs. Assumes the emulation strobes are single-cycle.
module ccm_trigger_path #(
    parameter int BUNCH_W = 8,
    parameter int TYPE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               local_i,
    input  logic               run_i,
    input  logic               up_accept_i,
    input  logic               up_testp_i,
    input  logic [BUNCH_W-1:0] up_bunch_i,
    input  logic [TYPE_W-1:0]  up_type_i,
    input  logic               emu_acc_i,
    input  logic               emu_tp_i,
    input  logic               emu_bx_we_i,
    input  logic               emu_typ_we_i,
    input  logic [BUNCH_W-1:0] emu_bx_i,
    input  logic [TYPE_W-1:0]  emu_typ_i,
    output logic               cap_acc_o,
    output logic               cap_tp_o,
    output logic [BUNCH_W-1:0] cap_bx_o,
    output logic [TYPE_W-1:0]  cap_typ_o,
    output logic               trig_o,
    output logic               testp_o
);

    logic               cap_acc_q, cap_tp_q;
    logic [BUNCH_W-1:0] cap_bx_q;
    logic [TYPE_W-1:0]  cap_typ_q;
    logic               trig_q, testp_q;

    // Capture stage: upstream values, or bus emulation in local mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_acc_q <= 1'b0;
            cap_tp_q  <= 1'b0;
            cap_bx_q  <= '0;
            cap_typ_q <= '0;
        end else if (local_i) begin
            cap_acc_q <= emu_acc_i;
            cap_tp_q  <= emu_tp_i;
            if (emu_bx_we_i)  cap_bx_q  <= emu_bx_i;
            if (emu_typ_we_i) cap_typ_q <= emu_typ_i;
        end else begin
            cap_acc_q <= up_accept_i;
            cap_tp_q  <= up_testp_i;
            cap_bx_q  <= up_bunch_i;
            cap_typ_q <= up_type_i;
        end
    end

    // Output stage on the readout clock; triggers only pass in RUN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            testp_q <= 1'b0;
        end else begin
            trig_q  <= cap_acc_q & run_i;
            testp_q <= cap_tp_q;
        end
    end

    // Drive outputs from the registers
    always_comb begin
        cap_acc_o = cap_acc_q;
        cap_tp_o  = cap_tp_q;
        cap_bx_o  = cap_bx_q;
        cap_typ_o = cap_typ_q;
        trig_o    = trig_q;
        testp_o   = testp_q;
    end

endmodule

// File: rtl/ccm_regbank.sv
// Register bus decode: command and mask registers, emulation write strobes
// (qualified by local mode), and the combinational read multiplexer.
// Assumes a write is a single-cycle strobe sampled at the clock edge.
module ccm_regbank
    import ccm_pkg::*;
#(
    parameter int N_SLAVE = 4,
    parameter int DATA_W  = 16,
    parameter int BUNCH_W = 8,
    parameter int TYPE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               local_o,
    output logic [N_SLAVE-1:0] mask_o,
    output logic               glob_rst_o,
    output logic               emu_acc_o,
    output logic               emu_tp_o,
    output logic               emu_bx_we_o,
    output logic               emu_typ_we_o,
    input  logic               cap_acc_i,
    input  logic               cap_tp_i,
    input  logic [BUNCH_W-1:0] cap_bx_i,
    input  logic [TYPE_W-1:0]  cap_typ_i,
    input  logic [N_SLAVE-1:0] sl_busy_i,
    input  logic [N_SLAVE-1:0] sl_err_i,
    input  logic [N_SLAVE-1:0] sl_fatal_i,
    input  logic [1:0]         state_i,
    input  logic               trig_i,
    input  logic               testp_i,
    input  logic               fe_rst_n_i
);

    localparam int SL_W = 3 * N_SLAVE;

    logic               local_q;
    logic [N_SLAVE-1:0] mask_q;
    logic [7:0]         hit;
    logic               unused_wdata;

    // One-hot address decode of a write
    for (genvar a = 0; a < 8; a++) begin : g_dec
        assign hit[a] = wr_i && (addr_i == ADDR_W'(a));
    end

    // Always-writable command and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_q <= 1'b0;
            mask_q  <= '0;
        end else begin
            if (hit[A_CMD])  local_q <= wdata_i[0];
            if (hit[A_MASK]) mask_q  <= wdata_i[N_SLAVE-1:0];
        end
    end

    // Strobes: global reset always, emulation only in local mode
    always_comb begin
        glob_rst_o   = hit[A_CMD] & wdata_i[1];
        emu_acc_o    = local_q & hit[A_EMU_ACC] & wdata_i[0];
        emu_tp_o     = local_q & hit[A_EMU_TP]  & wdata_i[0];
        emu_bx_we_o  = local_q & hit[A_EMU_BX];
        emu_typ_we_o = local_q & hit[A_EMU_TYP];
        local_o      = local_q;
        mask_o       = mask_q;
    end

    // Read multiplexer
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_CMD:     rdata_o[0]            = local_q;
            A_MASK:    rdata_o[N_SLAVE-1:0]  = mask_q;
            A_EMU_ACC: rdata_o[0]            = cap_acc_i;
            A_EMU_TP:  rdata_o[0]            = cap_tp_i;
            A_EMU_BX:  rdata_o[BUNCH_W-1:0]  = cap_bx_i;
            A_EMU_TYP: rdata_o[TYPE_W-1:0]   = cap_typ_i;
            A_STAT_SL: rdata_o[SL_W-1:0]     = {sl_fatal_i, sl_err_i, sl_busy_i};
            A_STAT_FE: rdata_o[4:0]          = {fe_rst_n_i, testp_i, trig_i, state_i};
            default:   rdata_o               = '0;
        endcase
    end

    assign unused_wdata = ^wdata_i;

endmodule

// File: rtl/ccm_master.sv
// Top of the trigger clock-and-control master. Wires the register bank,
// trigger capture/output path, return combiner and control state machine.
// Assumes all inputs are synchronous to clk.
module ccm_master
    import ccm_pkg::*;
#(
    parameter int N_SLAVE = 4,
    parameter int DATA_W  = 16,
    parameter int BUNCH_W = 8,
    parameter int TYPE_W  = 4,
    parameter int RST_CYC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_accept_i,
    input  logic               up_testp_i,
    input  logic [BUNCH_W-1:0] up_bunch_i,
    input  logic [TYPE_W-1:0]  up_type_i,
    input  logic [N_SLAVE-1:0] sl_busy_i,
    input  logic [N_SLAVE-1:0] sl_err_i,
    input  logic [N_SLAVE-1:0] sl_fatal_i,
    input  logic               bus_wr_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               trig_o,
    output logic               testp_o,
    output logic               ro_clk_o,
    output logic               busy_o,
    output logic               fatal_o,
    output logic               fe_rst_n_o
);

    logic               local_mode;
    logic [N_SLAVE-1:0] mask_q;
    logic               glob_rst;
    logic               emu_acc, emu_tp, emu_bx_we, emu_typ_we;
    logic               cap_acc, cap_tp;
    logic [BUNCH_W-1:0] cap_bx;
    logic [TYPE_W-1:0]  cap_typ;
    logic               busy_any, err_any, fatal_any;
    ccm_state_e         state_q;
    logic               run;

    ccm_regbank #(
        .N_SLAVE(N_SLAVE), .DATA_W(DATA_W), .BUNCH_W(BUNCH_W), .TYPE_W(TYPE_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
        .rdata_o(bus_rdata_o),
        .local_o(local_mode), .mask_o(mask_q), .glob_rst_o(glob_rst),
        .emu_acc_o(emu_acc), .emu_tp_o(emu_tp),
        .emu_bx_we_o(emu_bx_we), .emu_typ_we_o(emu_typ_we),
        .cap_acc_i(cap_acc), .cap_tp_i(cap_tp),
        .cap_bx_i(cap_bx), .cap_typ_i(cap_typ),
        .sl_busy_i(sl_busy_i), .sl_err_i(sl_err_i), .sl_fatal_i(sl_fatal_i),
        .state_i(state_q), .trig_i(trig_o), .testp_i(testp_o),
        .fe_rst_n_i(fe_rst_n_o)
    );

    ccm_trigger_path #(.BUNCH_W(BUNCH_W), .TYPE_W(TYPE_W)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .local_i(local_mode), .run_i(run),
        .up_accept_i(up_accept_i), .up_testp_i(up_testp_i),
        .up_bunch_i(up_bunch_i), .up_type_i(up_type_i),
        .emu_acc_i(emu_acc), .emu_tp_i(emu_tp),
        .emu_bx_we_i(emu_bx_we), .emu_typ_we_i(emu_typ_we),
        .emu_bx_i(bus_wdata_i[BUNCH_W-1:0]), .emu_typ_i(bus_wdata_i[TYPE_W-1:0]),
        .cap_acc_o(cap_acc), .cap_tp_o(cap_tp),
        .cap_bx_o(cap_bx), .cap_typ_o(cap_typ),
        .trig_o(trig_o), .testp_o(testp_o)
    );

    ccm_return_combiner #(.N_SLAVE(N_SLAVE)) u_comb (
        .busy_i(sl_busy_i), .err_i(sl_err_i), .fatal_i(sl_fatal_i),
        .mask_i(mask_q),
        .busy_any_o(busy_any), .err_any_o(err_any), .fatal_any_o(fatal_any)
    );

    ccm_ctrl_fsm #(.RST_CYC(RST_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .glob_rst_i(glob_rst), .err_any_i(err_any), .fatal_any_i(fatal_any),
        .state_o(state_q), .fe_rst_n_o(fe_rst_n_o)
    );

    // Upstream returns and readout clock
    always_comb begin
        run      = (state_q == ST_RUN);
        busy_o   = busy_any | !run;
        fatal_o  = fatal_any | (state_q == ST_FATAL);
        ro_clk_o = clk;
    end

endmodule

// File: rtl/ccm_master_chk.sv
// Property checker for ccm_master, attached by bind below.
module ccm_master_chk #(
    parameter int N_SLAVE = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_SLAVE-1:0] sl_busy_i,
    input logic [N_SLAVE-1:0] sl_fatal_i,
    input logic [N_SLAVE-1:0] mask_q,
    input logic [1:0]         state_q,
    input logic               glob_rst,
    input logic               trig_o,
    input logic               busy_o,
    input logic               fatal_o,
    input logic               fe_rst_n_o
);

    AST_BUSY_COVERS_SLAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sl_busy_i & ~mask_q)) |-> busy_o); // R3

    AST_FATAL_COVERS_SLAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sl_fatal_i & ~mask_q)) |-> fatal_o); // R4

    AST_FE_RESET_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !fe_rst_n_o |-> busy_o); // R5

    AST_FE_RESET_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fe_rst_n_o) |=> !fe_rst_n_o); // R5

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd2 && !glob_rst) |=> (state_q == 2'd2 && fatal_o)); // R6

    AST_GLOBAL_RESET_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        glob_rst |=> (state_q == 2'd0)); // R7

    AST_TRIG_ONLY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_o) |-> ($past(state_q) == 2'd0)); // R11

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3); // R6

endmodule

bind ccm_master ccm_master_chk #(.N_SLAVE(N_SLAVE)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .sl_busy_i(sl_busy_i), .sl_fatal_i(sl_fatal_i),
    .mask_q(mask_q), .state_q(state_q), .glob_rst(glob_rst),
    .trig_o(trig_o), .busy_o(busy_o), .fatal_o(fatal_o),
    .fe_rst_n_o(fe_rst_n_o)
);

// File: tb/tb_ccm_master.sv
// Self-checking bench for ccm_master: directed corner cases plus a seeded
// random phase on the upstream path and busy combining.
module tb_ccm_master;

    localparam time CLK_PERIOD = 96ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_accept, up_testp;
    logic [7:0]  up_bunch;
    logic [3:0]  up_type;
    logic [3:0]  sl_busy, sl_err, sl_fatal;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        trig_o, testp_o, ro_clk_o, busy_o, fatal_o, fe_rst_n_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ccm_master dut (
        .clk(clk), .rst_n(rst_n),
        .up_accept_i(up_accept), .up_testp_i(up_testp),
        .up_bunch_i(up_bunch), .up_type_i(up_type),
        .sl_busy_i(sl_busy), .sl_err_i(sl_err), .sl_fatal_i(sl_fatal),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .trig_o(trig_o), .testp_o(testp_o), .ro_clk_o(ro_clk_o),
        .busy_o(busy_o), .fatal_o(fatal_o), .fe_rst_n_o(fe_rst_n_o)
    );

    function automatic logic exp_busy(input logic [3:0] b, input logic [3:0] m,
                                      input logic in_run);
        return (|(b & ~m)) | !in_run;
    endfunction

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int          lows;
        logic        h1_acc, h1_tp, h2_acc, h2_tp;
        logic [7:0]  h1_bx;
        logic [3:0]  mask_r;
        int unsigned seed_init;

        seed_init = $urandom(32'h5EED_0C0C);
        rst_n = 1'b0; up_accept = 0; up_testp = 0; up_bunch = '0; up_type = '0;
        sl_busy = '0; sl_err = '0; sl_fatal = '0;
        bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 trig", trig_o, 0);
        check("R1 testp", testp_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 fatal", fatal_o, 0);
        check("R1 fe_rst_n", fe_rst_n_o, 1);
        bus_read(3'd7, rd); check("R1 state", rd[1:0], 0);
        bus_read(3'd0, rd); check("R1 cmd", rd, 0);
        bus_read(3'd1, rd); check("R1 mask", rd, 0);

        // R12 readout clock follows clk
        @(negedge clk); check("R12 low phase", ro_clk_o, 0);
        @(posedge clk); #1; check("R12 high phase", ro_clk_o, 1);

        // R2 directed upstream accept latency
        @(negedge clk); up_accept = 1; up_bunch = 8'hC3; up_type = 4'h9;
        @(negedge clk); up_accept = 0;
        bus_read(3'd4, rd); check("R2 bunch readback", rd, 16'h00C3);
        bus_read(3'd5, rd); check("R2 type readback", rd, 16'h0009);
        check("R2 trig not yet", trig_o, 0);
        @(negedge clk); check("R2 trig pulse", trig_o, 1);
        @(negedge clk); check("R2 trig single", trig_o, 0);

        // R2/R3 random phase: upstream inputs and masked busy
        for (int blk = 0; blk < 8; blk++) begin
            mask_r = 4'($urandom);
            bus_write(3'd1, {12'h0, mask_r});
            bus_read(3'd1, rd); check("R8 mask readback", rd, {12'h0, mask_r});
            up_accept = 0; up_testp = 0;
            @(negedge clk); @(negedge clk);
            h1_acc = 0; h1_tp = 0; h2_acc = 0; h2_tp = 0; h1_bx = up_bunch;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                check("R2 trig random", trig_o, h2_acc);
                check("R2 testp random", testp_o, h2_tp);
                bus_read(3'd4, rd); check("R2 bunch random", rd, {8'h0, h1_bx});
                h2_acc = h1_acc; h2_tp = h1_tp;
                up_accept = 1'($urandom); up_testp = 1'($urandom);
                up_bunch = 8'($urandom); up_type = 4'($urandom);
                sl_busy = 4'($urandom);
                h1_acc = up_accept; h1_tp = up_testp; h1_bx = up_bunch;
                #1;
                check("R3 busy random", busy_o, exp_busy(sl_busy, mask_r, 1'b1));
            end
        end
        up_accept = 0; up_testp = 0; sl_busy = '0;
        bus_write(3'd1, 16'h0);
        @(negedge clk); @(negedge clk);

        // R10/R3/R4 status with everything masked
        bus_write(3'd1, 16'h000F);
        sl_busy = 4'h3; sl_err = 4'hA; sl_fatal = 4'h5;
        bus_read(3'd6, rd); check("R10 slave status", rd, 16'h05A3);
        check("R3 all masked busy", busy_o, 0);
        check("R4 all masked fatal", fatal_o, 0);
        @(negedge clk); @(negedge clk);
        bus_read(3'd7, rd); check("R5 masked err keeps RUN", rd[1:0], 0);
        check("R5 masked err no fe reset", fe_rst_n_o, 1);
        sl_busy = 0; sl_err = 0; sl_fatal = 0;
        bus_write(3'd1, 16'h0);

        // R5 reset-request pulse: exactly 4 low cycles, then RUN
        @(negedge clk); sl_err = 4'h2;
        @(negedge clk); sl_err = 4'h0;
        bus_read(3'd7, rd); check("R5 state RESETTING", rd[1:0], 1);
        check("R3 busy while resetting", busy_o, 1);
        lows = 0;
        for (int k = 0; k < 8; k++) begin
            if (!fe_rst_n_o) lows++;
            @(negedge clk);
        end
        check("R5 fe reset width", lows, 4);
        check("R5 busy after recovery", busy_o, 0);
        bus_read(3'd7, rd); check("R5 back to RUN", rd[1:0], 0);

        // R5 held request keeps RESETTING after the reset pulse
        @(negedge clk); sl_err = 4'h8;
        repeat (10) @(negedge clk);
        check("R5 fe reset released", fe_rst_n_o, 1);
        check("R5 busy while held", busy_o, 1);
        bus_read(3'd7, rd); check("R5 still RESETTING", rd, 16'h0011);
        sl_err = 4'h0;
        @(negedge clk);
        check("R5 busy clears", busy_o, 0);

        // R5 masked request has no effect
        bus_write(3'd1, 16'h0002);
        @(negedge clk); sl_err = 4'h2;
        lows = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!fe_rst_n_o) lows++;
        end
        sl_err = 0;
        check("R5 masked no reset", lows, 0);
        check("R3 masked no busy", busy_o, 0);
        bus_write(3'd1, 16'h0);

        // R6 fatal is sticky; R11 trigger suppressed
        @(negedge clk); sl_fatal = 4'h4;
        @(negedge clk); sl_fatal = 4'h0;
        @(negedge clk);
        check("R4 fatal out", fatal_o, 1);
        check("R3 busy in fatal", busy_o, 1);
        bus_read(3'd7, rd); check("R6 state FATAL", rd[1:0], 2);
        up_accept = 1;
        @(negedge clk); up_accept = 0;
        @(negedge clk); check("R11 no trig in FATAL", trig_o, 0);
        @(negedge clk); check("R11 no trig later", trig_o, 0);
        bus_write(3'd1, 16'h000F);
        @(negedge clk);
        bus_read(3'd7, rd); check("R6 FATAL survives mask", rd[1:0], 2);
        bus_write(3'd1, 16'h0);
        bus_write(3'd0, 16'h0002);
        check("R7 global reset clears fatal", fatal_o, 0);
        check("R7 global reset clears busy", busy_o, 0);
        bus_read(3'd0, rd); check("R7 cmd bit1 reads 0", rd, 0);

        // R9 local mode one-shots and emulation registers
        bus_write(3'd0, 16'h0001);
        bus_read(3'd0, rd); check("R7 local bit", rd, 1);
        bus_write(3'd2, 16'h0001);
        check("R9 trig not yet", trig_o, 0);
        @(negedge clk); check("R9 trig one-shot", trig_o, 1);
        @(negedge clk); check("R9 trig single", trig_o, 0);
        bus_write(3'd3, 16'h0001);
        @(negedge clk); check("R9 testp one-shot", testp_o, 1);
        @(negedge clk); check("R9 testp single", testp_o, 0);
        up_bunch = 8'hFF; up_type = 4'hF;
        bus_write(3'd4, 16'h005A);
        bus_write(3'd5, 16'h0006);
        bus_read(3'd4, rd); check("R9 emu bunch", rd, 16'h005A);
        bus_read(3'd5, rd); check("R9 emu type", rd, 16'h0006);
        up_accept = 1; up_testp = 1;
        lows = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (trig_o || testp_o) lows++;
        end
        up_accept = 0; up_testp = 0;
        check("R9 upstream ignored in local", lows, 0);

        // R9 emulation writes ignored in upstream mode
        bus_write(3'd0, 16'h0000);
        up_bunch = 8'h3C;
        bus_write(3'd4, 16'h0011);
        bus_read(3'd4, rd); check("R9 upstream bunch wins", rd, 16'h003C);
        bus_write(3'd2, 16'h0001);
        @(negedge clk); check("R9 accept write ignored", trig_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule